// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit gathers the event flags of a display controller that has seven frame-fetch channels and turns them into one level-sensitive interrupt request. Each channel can report start-of-frame, end-of-frame and branch events. The controller core reports input underrun on channels 0 and 1, output underrun, bus errors, the quick-disable acknowledge, last-frame-done, AC-bias count, read-status and command completion. Every event arrives as a one-cycle strobe and sets a sticky flag. Software clears a flag by writing a one to it.

Channel 0 and the core events share the first status word. Channels 1 to 6 keep their own flags in the second status word. The mask bits come in as images of two control words, and each mask bit suppresses one flag's part in the interrupt. When the first unmasked frame event arrives, the frame ID of the reporting channel is captured in an ID register. An event that arrives while the interrupt line is already high does not overwrite that ID. It sets a "subsequent interrupt" flag instead. A bus error also records the number of the failing channel.

Top module: `lcd_irq_status`

## Requirements
- R1: While reset is asserted, both status words, the ID register and the interrupt output are zero.
- R2: In status word 0, strobes set sticky flags at these bits: last-frame-done 0, channel-0 start-of-frame 1, bus error 2, AC-bias 3, underrun ch0 4, underrun ch1 5, output underrun 6, quick-disable 7, channel-0 end-of-frame 8, channel-0 branch 9, subsequent 10, read-status 11, command 12. Each flag is set on the clock edge that samples its strobe.
- R3: For channel c from 1 to 6, status word 1 holds start-of-frame at bit c-1, end-of-frame at bit c+7 and branch at bit c+15. A start-of-frame or end-of-frame strobe is recorded only if that channel's start-enable or end-enable input is high. Branch strobes need no enable.
- R4: The interrupt output is high exactly when one of these holds. The first case is a status-0 flag that is set while its mask is clear. The masks are control-0 bits 3 (done), 4 (SOF0), 5 (UR0), 6 (EOF0), 11 (quick-disable), 20 (branch0), 21 (output underrun), 23 (read-status) and 24 (command), and control-5 bit 24 masks UR1. The second case is a status-1 bit that is set while the same control-5 bit is clear.
- R5: Suppose the interrupt line is low and an unmasked start-of-frame, end-of-frame or branch event, or a bus error, is recorded. Then the frame ID of that channel is captured. A bus error takes priority, and otherwise the lowest-numbered channel wins.
- R6: Suppose the interrupt line is high when such an event is recorded. Then status-0 bit 10 is set and the ID register keeps its value.
- R7: A bus error sets status-0 bit 2 and puts the channel number into bits 30:28, whatever the masks are.
- R8: A write to status word 0 clears each of bits 11:0 that is written as one. Writing one to bit 2 also clears bits 30:28. Bit 12 is not cleared by writes.
- R9: A write to status word 1 clears only the written-one bits that fall inside 0x003E3F3F. Bit 16 (branch, channel 1) is therefore kept.
- R10: When control-0 bit 0 (enable) goes from one to zero, status-0 bit 7 is set.
- R11: If a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl0_i | input | 32 | Control word 0 image (enable and status-0 masks) |
| ctl5_i | input | 32 | Control word 5 image (per-channel masks) |
| sof_ev_i | input | 7 | Start-of-frame strobes, one per channel |
| sof_en_i | input | 7 | Start-interrupt enable from each channel's command word |
| eof_ev_i | input | 7 | End-of-frame strobes |
| eof_en_i | input | 7 | End-interrupt enable from each channel's command word |
| br_ev_i | input | 7 | Branch strobes |
| ur_ev_i | input | 2 | Input underrun strobes for channels 0 and 1 |
| ldd_ev_i | input | 1 | Last-frame-done strobe |
| abc_ev_i | input | 1 | AC-bias count strobe |
| ou_ev_i | input | 1 | Output underrun strobe |
| rdst_ev_i | input | 1 | Read-status strobe |
| cmd_ev_i | input | 1 | Command-done strobe |
| ber_ev_i | input | 1 | Bus error strobe |
| ber_ch_i | input | 3 | Channel (0 to 6) that had the bus error |
| fid_i | input | 7*IDW | Frame IDs, channel c at bits c*IDW upward |
| wr0_i | input | 1 | Write-one-to-clear strobe for status word 0 |
| wr1_i | input | 1 | Write-one-to-clear strobe for status word 1 |
| wdata_i | input | 32 | Write data |
| stat0_o | output | 32 | Status word 0 |
| stat1_o | output | 32 | Status word 1 |
| iid_o | output | IDW | Captured interrupt frame ID |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two actions can land in the same cycle: an event strobe that sets a flag, and a software write that clears the same flag. The bench pulses last-frame-done together with a status-0 write of bit 0. The flag must stay set. Two channels also report unmasked events in one cycle, and only the lower channel's ID may be captured. A behavioural model computes the expected registers on every clock and compares them with the outputs.

// File: rtl/lcd_irq_status.sv
module lcd_irq_status #(
  parameter int IDW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    ctl0_i,
  input  logic [31:0]    ctl5_i,
  input  logic [6:0]     sof_ev_i,
  input  logic [6:0]     sof_en_i,
  input  logic [6:0]     eof_ev_i,
  input  logic [6:0]     eof_en_i,
  input  logic [6:0]     br_ev_i,
  input  logic [1:0]     ur_ev_i,
  input  logic           ldd_ev_i,
  input  logic           abc_ev_i,
  input  logic           ou_ev_i,
  input  logic           rdst_ev_i,
  input  logic           cmd_ev_i,
  input  logic           ber_ev_i,
  input  logic [2:0]     ber_ch_i,
  input  logic [7*IDW-1:0] fid_i,
  input  logic           wr0_i,
  input  logic           wr1_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    stat0_o,
  output logic [31:0]    stat1_o,
  output logic [IDW-1:0] iid_o,
  output logic           irq_o
);
  localparam int NCH = 7;
  localparam logic [31:0] CLR1_MASK = 32'h003E3F3F;

  logic [31:0] s0, s1;
  logic [IDW-1:0] iid;
  logic en_q;
  logic [NCH-1:0] sof_hit, eof_hit, sof_m, eof_m, br_m, cap_ch;
  logic [12:0] set0, msk0;
  logic [31:0] set1;
  logic [2:0] sel;
  logic any_cap;
  logic [IDW-1:0] fid_a [8];

  wire unused_ctl = ^{ctl0_i[31:25], ctl0_i[22], ctl0_i[19:12], ctl0_i[10:7], ctl0_i[2:1]};

  for (genvar c = 0; c < 8; c++) begin : g_fid
    if (c < NCH) begin : g_ch
      assign fid_a[c] = fid_i[c*IDW +: IDW];
    end else begin : g_none
      assign fid_a[c] = '0;
    end
  end

  assign sof_hit = sof_ev_i & sof_en_i;
  assign eof_hit = eof_ev_i & eof_en_i;

  always_comb begin
    sof_m[0] = ctl0_i[4];
    eof_m[0] = ctl0_i[6];
    br_m[0]  = ctl0_i[20];
    set1 = '0;
    for (int c = 1; c < NCH; c++) begin
      sof_m[c] = ctl5_i[c-1];
      eof_m[c] = ctl5_i[c+7];
      br_m[c]  = ctl5_i[c+15];
      set1[c-1]  = sof_hit[c];
      set1[c+7]  = eof_hit[c];
      set1[c+15] = br_ev_i[c];
    end
  end

  assign cap_ch  = (sof_hit & ~sof_m) | (eof_hit & ~eof_m) | (br_ev_i & ~br_m);
  assign any_cap = ber_ev_i | (|cap_ch);

  always_comb begin
    sel = ber_ch_i;
    if (!ber_ev_i)
      for (int c = NCH-1; c >= 0; c--)
        if (cap_ch[c]) sel = 3'(c);
  end

  assign msk0 = {ctl0_i[24], ctl0_i[23], 1'b1, ctl0_i[20], ctl0_i[6], ctl0_i[11],
                 ctl0_i[21], ctl5_i[24], ctl0_i[5], 1'b1, 1'b1, ctl0_i[4], ctl0_i[3]};
  assign irq_o = (|(s0[12:0] & ~msk0)) | (|(s1 & ~ctl5_i));

  assign set0 = {cmd_ev_i, rdst_ev_i, irq_o & any_cap, br_ev_i[0], eof_hit[0],
                 en_q & ~ctl0_i[0], ou_ev_i, ur_ev_i[1], ur_ev_i[0], abc_ev_i,
                 ber_ev_i, sof_hit[0], ldd_ev_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0   <= '0;
      s1   <= '0;
      iid  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= ctl0_i[0];
      s0[12:0] <= (s0[12:0] & ~(wr0_i ? {1'b0, wdata_i[11:0]} : 13'd0)) | set0;
      if (ber_ev_i)
        s0[30:28] <= ber_ch_i;
      else if (wr0_i && wdata_i[2])
        s0[30:28] <= 3'd0;
      s1 <= (s1 & ~(wr1_i ? (wdata_i & CLR1_MASK) : 32'd0)) | set1;
      if (any_cap && !irq_o)
        iid <= fid_a[sel];
    end
  end

  assign stat0_o = s0;
  assign stat1_o = s1;
  assign iid_o   = iid;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (stat0_o == 32'd0 && stat1_o == 32'd0 && iid_o == '0));

  assert_busy_keeps_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && any_cap) |=> (stat0_o[10] && iid_o == $past(iid_o)));

  assert_berr_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ber_ev_i |=> (stat0_o[2] && stat0_o[30:28] == $past(ber_ch_i)));

  assert_quick_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ctl0_i[0]) |=> stat0_o[7]);

  assert_keep_ch1_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1_i && stat1_o[16]) |=> stat1_o[16]);
endmodule

// File: tb/lcd_irq_status_tb.sv
`timescale 1ns/100ps
module lcd_irq_status_tb;
  localparam int IDW = 16;
  localparam logic [31:0] M0 = 32'h01B00878;

  logic clk = 0, rst_n = 0;
  logic [31:0] ctl0 = M0, ctl5 = 32'hFFFFFFFF, wdata = 0;
  logic [6:0] sof_ev = 0, sof_en = 0, eof_ev = 0, eof_en = 0, br_ev = 0;
  logic [1:0] ur_ev = 0;
  logic ldd = 0, abc = 0, ou = 0, rdst = 0, cmdv = 0, ber = 0, wr0 = 0, wr1 = 0;
  logic [2:0] ber_ch = 0;
  logic [7*IDW-1:0] fid;
  logic [31:0] stat0, stat1;
  logic [IDW-1:0] iid;
  logic irq;

  int checks = 0, fails = 0, cycles = 0;
  string cur = "R1";

  for (genvar c = 0; c < 7; c++) begin : g_fid
    assign fid[c*IDW +: IDW] = 16'h1100 + 16'(c);
  end

  always #2.5 clk = ~clk;

  lcd_irq_status #(.IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl0_i(ctl0), .ctl5_i(ctl5),
    .sof_ev_i(sof_ev), .sof_en_i(sof_en), .eof_ev_i(eof_ev), .eof_en_i(eof_en),
    .br_ev_i(br_ev), .ur_ev_i(ur_ev), .ldd_ev_i(ldd), .abc_ev_i(abc), .ou_ev_i(ou),
    .rdst_ev_i(rdst), .cmd_ev_i(cmdv), .ber_ev_i(ber), .ber_ch_i(ber_ch), .fid_i(fid),
    .wr0_i(wr0), .wr1_i(wr1), .wdata_i(wdata),
    .stat0_o(stat0), .stat1_o(stat1), .iid_o(iid), .irq_o(irq));

  // behavioural reference
  logic [31:0] m0 = 0, m1 = 0;
  logic [15:0] miid = 0;
  logic men = 0;

  function automatic logic model_irq();
    logic r;
    r = 0;
    if (m0[0]  && !ctl0[3])  r = 1;
    if (m0[1]  && !ctl0[4])  r = 1;
    if (m0[4]  && !ctl0[5])  r = 1;
    if (m0[5]  && !ctl5[24]) r = 1;
    if (m0[6]  && !ctl0[21]) r = 1;
    if (m0[7]  && !ctl0[11]) r = 1;
    if (m0[8]  && !ctl0[6])  r = 1;
    if (m0[9]  && !ctl0[20]) r = 1;
    if (m0[11] && !ctl0[23]) r = 1;
    if (m0[12] && !ctl0[24]) r = 1;
    if ((m1 & ~ctl5) != 0)   r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    logic [31:0] n0, n1;
    int who;
    logic busy;
    if (!rst_n) begin
      m0 <= 0; m1 <= 0; miid <= 0; men <= 0;
    end else begin
      busy = model_irq();
      n0 = m0; n1 = m1; who = -1;
      if (wr0) begin
        n0 = n0 & ~(wdata & 32'hFFF);
        if (wdata[2]) n0[30:28] = 0;
      end
      if (wr1) n1 = n1 & ~(wdata & 32'h003E3F3F);
      for (int c = 0; c < 7; c++) begin
        if (sof_ev[c] && sof_en[c]) begin
          if (c == 0) begin n0[1] = 1; if (!ctl0[4] && who < 0) who = 0; end
          else begin n1[c-1] = 1; if (!ctl5[c-1] && who < 0) who = c; end
        end
        if (eof_ev[c] && eof_en[c]) begin
          if (c == 0) begin n0[8] = 1; if (!ctl0[6] && who < 0) who = 0; end
          else begin n1[c+7] = 1; if (!ctl5[c+7] && who < 0) who = c; end
        end
        if (br_ev[c]) begin
          if (c == 0) begin n0[9] = 1; if (!ctl0[20] && who < 0) who = 0; end
          else begin n1[c+15] = 1; if (!ctl5[c+15] && who < 0) who = c; end
        end
      end
      if (ber) begin n0[2] = 1; n0[30:28] = ber_ch; who = int'(ber_ch); end
      if (ldd) n0[0] = 1;
      if (abc) n0[3] = 1;
      if (ur_ev[0]) n0[4] = 1;
      if (ur_ev[1]) n0[5] = 1;
      if (ou) n0[6] = 1;
      if (men && !ctl0[0]) n0[7] = 1;
      if (rdst) n0[11] = 1;
      if (cmdv) n0[12] = 1;
      if (who >= 0) begin
        if (busy) n0[10] = 1;
        else miid <= 16'h1100 + 16'(who);
      end
      m0 <= n0; m1 <= n1; men <= ctl0[0];
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(cur, "model stat0", stat0, m0);
      chk(cur, "model stat1", stat1, m1);
      chk(cur, "model iid", 32'(iid), 32'(miid));
      chk(cur, "model irq", 32'(irq), 32'(model_irq()));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    sof_ev = 0; eof_ev = 0; br_ev = 0; ur_ev = 0;
    ldd = 0; abc = 0; ou = 0; rdst = 0; cmdv = 0; ber = 0; wr0 = 0; wr1 = 0;
  endtask

  task automatic clear_all();
    ctl0 = M0; ctl5 = 32'hFFFFFFFF;
    wr0 = 1; wr1 = 1; wdata = 32'hFFFFFFFF; tick(); quiet();
  endtask

  initial begin
    repeat (3) tick();
    cur = "R1";
    chk("R1", "stat0 in reset", stat0, 0);
    chk("R1", "stat1 in reset", stat1, 0);
    chk("R1", "irq in reset", 32'(irq), 0);
    rst_n = 1; tick();

    cur = "R2";
    ldd = 1; abc = 1; ou = 1; ur_ev = 2'b11; rdst = 1; cmdv = 1; tick(); quiet();
    chk("R2", "core flags", stat0, 32'h00001879);
    chk("R2", "masked irq", 32'(irq), 0);

    cur = "R4";
    ctl0 = M0 & ~32'h8; tick();
    chk("R4", "unmasked done irq", 32'(irq), 1);
    ctl0 = M0; tick();
    chk("R4", "remasked irq", 32'(irq), 0);

    cur = "R8";
    wr0 = 1; wdata = 32'hFFF; tick(); quiet();
    chk("R8", "bit12 kept", stat0, 32'h00001000);

    cur = "R3";
    sof_ev[3] = 1; tick(); quiet();
    chk("R3", "sof disabled", stat1, 0);
    sof_en = 7'h7F; eof_en = 7'h7F;
    sof_ev[3] = 1; tick(); quiet();
    chk("R3", "sof ch3", stat1, 32'h4);
    clear_all(); tick();

    cur = "R5";
    ctl5 = ~32'h12; sof_ev[2] = 1; sof_ev[5] = 1; tick(); quiet();
    chk("R5", "stat1", stat1, 32'h12);
    chk("R5", "lowest channel id", 32'(iid), 32'h1102);
    chk("R5", "irq", 32'(irq), 1);

    cur = "R6";
    ctl0 = M0 & ~32'h40; eof_ev[0] = 1; tick(); quiet();
    chk("R6", "subsequent flag", stat0, 32'h00001500);
    chk("R6", "id kept", 32'(iid), 32'h1102);
    clear_all(); tick();
    chk("R6", "cleared", stat0, 32'h00001000);

    cur = "R7";
    ber = 1; ber_ch = 3'd5; tick(); quiet();
    chk("R7", "ber field", stat0, 32'h50001004);
    chk("R7", "ber id", 32'(iid), 32'h1105);
    wr0 = 1; wdata = 32'h4; tick(); quiet();
    chk("R8", "ber field cleared", stat0, 32'h00001000);

    cur = "R9";
    br_ev[1] = 1; eof_ev[1] = 1; tick(); quiet();
    chk("R9", "ch1 flags", stat1, 32'h00010100);
    wr1 = 1; wdata = 32'hFFFFFFFF; tick(); quiet();
    chk("R9", "branch ch1 kept", stat1, 32'h00010000);

    cur = "R10";
    ctl0 = M0 | 32'h1; tick();
    ctl0 = M0; tick(); tick();
    chk("R10", "quick disable", stat0, 32'h00001080);

    cur = "R11";
    ldd = 1; wr0 = 1; wdata = 32'h1; tick(); quiet();
    chk("R11", "set beats clear", stat0, 32'h00001081);

    cur = "R2";
    sof_ev[0] = 1; br_ev[0] = 1; tick(); quiet();
    chk("R2", "ch0 sof and branch", stat0, 32'h00001283);
    repeat (4) tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule